// File: doc/BRIEF.md
# Two-Axis Center-Point Arc Stepper

This block drives two stepper axes along a circular arc. A move is described by the present position, the center of the circle and the end point, plus a rotation sense and a step period. Once started it emits one-cycle step pulses on the X and Y axes, each with a direction level, so that the resulting path follows the circle around the center until the end point is reached. Each step moves one axis, or both axes at once.

The step choice uses an integer error term equal to the squared distance from the center minus the squared start radius. The term is kept up to date with shift-and-add updates only, so the step loop holds no multiplier. At every step a primary axis always moves, and the other axis also moves when that gives a smaller error. The primary axis and both step signs come from the octant of the current point, so one rule set covers every quadrant in both rotation senses. Center and end can be given as absolute 32-bit positions or as 24-bit offsets from the start point. An optional constant-path-speed mode stretches the interval that follows a two-axis step by about 1.414.

Top module: `arcStepper`

## Requirements
- R1: While reset is held and after it is released, with no move started, stepX, stepY, dirX, dirY, busy and done are all 0.
- R2: With absMode=1, centerX/Y and endX/Y are signed 32-bit absolute positions. With absMode=0 they are offsets from startX/Y, taken from bits 23:0 sign-extended, and bits 31:24 are ignored.
- R3: A start pulse is accepted only while the block is idle, and busy is high from the next cycle. The first step pulse appears P cycles after the accepting clock edge, where P is period, or 1 when period is 0. Pulses are one cycle wide and occur only while busy is high, or together with done.
- R4: Each step pulse moves its axis by one unit. dirX and dirY are 1 for the increasing direction and 0 for the decreasing direction. Each is valid with its pulse and holds its value while that axis does not step.
- R5: The primary axis is X when |y| >= |x| and Y otherwise, with x and y measured from the center. ccw=1 runs counter-clockwise: X moves opposite to the sign of y and Y moves with the sign of x. ccw=0 reverses both. A zero coordinate counts as positive. The other axis also steps, in its own tangent sense, only when that gives a strictly smaller |x²+y²−r²|.
- R6: After every step the distance from the center stays within 1 unit of the start radius r, i.e. (r−1)² <= x²+y² <= (r+1)².
- R7: A move ends on the step that lands exactly on the end point. It also ends on a step that lands within 1 unit of the end point on both axes, provided the path has left that zone since the start. done is a one-cycle pulse coincident with the last step pulse, and busy falls in the same cycle.
- R8: When the end point equals the start point, a whole circle is traced before the move ends.
- R9: With constSpeed=1, the interval after a step that moved both axes is P + P>>2 + P>>3 + P>>5 + P>>7 cycles. Any other interval, and every interval with constSpeed=0, is P.
- R10: A start pulse arriving while busy is ignored, and the running move is not disturbed.
- R11: When the start point equals the center, done pulses in the cycle after acceptance with no step pulse, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a move (ignored while busy) |
| absMode | input | 1 | 1: center/end absolute, 0: 24-bit offsets from start |
| ccw | input | 1 | 1: counter-clockwise, 0: clockwise |
| constSpeed | input | 1 | Stretch the interval after a two-axis step |
| period | input | 16 | Cycles between steps (0 treated as 1) |
| startX | input | 32 | Current X position, signed absolute |
| startY | input | 32 | Current Y position, signed absolute |
| centerX | input | 32 | Circle center X (absolute or offset) |
| centerY | input | 32 | Circle center Y (absolute or offset) |
| endX | input | 32 | Arc end X (absolute or offset) |
| endY | input | 32 | Arc end Y (absolute or offset) |
| stepX | output | 1 | X step pulse |
| stepY | output | 1 | Y step pulse |
| dirX | output | 1 | X direction, 1 = increasing |
| dirY | output | 1 | Y direction, 1 = increasing |
| busy | output | 1 | Move in progress |
| done | output | 1 | One-cycle pulse when a move ends |

## Verification
Arcs are run in both rotation senses through quarter, half and whole circles. Between them these paths cross every octant boundary and every axis, so a wrong sign or primary-axis choice in any octant shows up as a trace mismatch or a radial error. Absolute and relative descriptions are both used, the relative one with junk in the unused upper bits, and a quarter arc near the top of the 32-bit range tests coordinate width. An end point set one unit off the circle tests near-end termination, and a full circle tests the rule that the path must leave the end zone before a near match counts. A start-equals-center case tests the zero-radius exit. Constant-speed runs and a period of zero tell the stretched interval apart from the plain one.

// File: rtl/arcPkg.sv
package arcPkg;
  // strobes from the sequencer to the arc datapath
  typedef struct packed {
    logic load;     // capture a new move
    logic advance;  // take one step now
  } arcStrobeT;
endpackage

// File: rtl/arcCtrl.sv
module arcCtrl
  import arcPkg::*;
#(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          constSpeed,
  input  logic [PW-1:0] period,
  input  logic          zeroRad,
  input  logic          finish,
  input  logic          diag,
  output arcStrobeT     strobe,
  output logic          busy,
  output logic          done
);
  localparam int TW = PW + 1;

  typedef enum logic { S_IDLE, S_RUN } stateT;

  stateT         state;
  logic [TW-1:0] cnt;
  logic [TW-1:0] intv;
  logic [TW-1:0] pLat;
  logic          csLat;
  logic [TW-1:0] pEff;
  logic          tick;

  // about 1.414 * p, built from shifts only
  function automatic logic [TW-1:0] stretch(input logic [TW-1:0] p);
    return p + (p >> 2) + (p >> 3) + (p >> 5) + (p >> 7);
  endfunction

  assign pEff = (period == '0) ? TW'(1) : TW'(period);
  assign tick = (cnt == intv - TW'(1));
  assign busy = (state == S_RUN);

  always_comb begin
    strobe.load    = (state == S_IDLE) && start;
    strobe.advance = (state == S_RUN) && tick;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      cnt   <= '0;
      intv  <= TW'(1);
      pLat  <= TW'(1);
      csLat <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            if (zeroRad) begin
              done <= 1'b1;
            end else begin
              state <= S_RUN;
              cnt   <= '0;
              intv  <= pEff;
              pLat  <= pEff;
              csLat <= constSpeed;
            end
          end
        end
        S_RUN: begin
          if (tick) begin
            cnt  <= '0;
            intv <= (csLat && diag) ? stretch(pLat) : pLat;
            if (finish) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end
          end else begin
            cnt <= cnt + TW'(1);
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/arcDatapath.sv
module arcDatapath
  import arcPkg::*;
#(
  parameter int CW = 32,
  parameter int RW = 24
) (
  input  logic          clk,
  input  logic          rstN,
  input  arcStrobeT     strobe,
  input  logic [CW-1:0] startX,
  input  logic [CW-1:0] startY,
  input  logic [CW-1:0] centerX,
  input  logic [CW-1:0] centerY,
  input  logic [CW-1:0] endX,
  input  logic [CW-1:0] endY,
  input  logic          absMode,
  input  logic          ccw,
  output logic          zeroRad,
  output logic          finish,
  output logic          diag,
  output logic          stepX,
  output logic          stepY,
  output logic          dirX,
  output logic          dirY
);
  localparam int IW = CW + 2;  // room for differences of two positions
  localparam int FW = IW + 3;  // room for error term plus both updates

  typedef logic signed [IW-1:0] coordT;
  typedef logic signed [FW-1:0] errT;

  function automatic coordT widen(input logic [CW-1:0] v);
    return coordT'($signed(v));
  endfunction

  function automatic coordT place(input logic [CW-1:0] base, input logic [CW-1:0] v,
                                  input logic absM);
    if (absM) return widen(v);
    return widen(base) + coordT'($signed(v[RW-1:0]));
  endfunction

  function automatic logic within1(input coordT d);
    return (d == coordT'(0)) || (d == coordT'(1)) || (d == coordT'(-1));
  endfunction

  coordT sAx, sAy, cAx, cAy, eAx, eAy;
  coordT px, py, ex, ey;
  errT   f;
  logic  armed, ccwR;

  coordT ax, ay, pv, cv, pv1, cv1, nx, ny, dxE, dyE;
  errT   twoP, twoC, fA, fB, magA, magB, fN;
  logic  xNeg, yNeg, xPrim, negP, negC, pv1Neg;
  logic  nearN, exactN, stepXn, stepYn, dirXn, dirYn;

  always_comb begin
    sAx = widen(startX);
    sAy = widen(startY);
    cAx = place(startX, centerX, absMode);
    cAy = place(startY, centerY, absMode);
    eAx = place(startX, endX, absMode);
    eAy = place(startY, endY, absMode);
  end

  assign zeroRad = (sAx == cAx) && (sAy == cAy);

  // octant decode and step selection
  always_comb begin
    xNeg  = px[IW-1];
    yNeg  = py[IW-1];
    ax    = xNeg ? -px : px;
    ay    = yNeg ? -py : py;
    xPrim = (ay >= ax);
    pv    = xPrim ? px : py;
    cv    = xPrim ? py : px;
    negP  = xPrim ? (ccwR ? !yNeg : yNeg) : (ccwR ? xNeg : !xNeg);
    pv1   = negP ? pv - coordT'(1) : pv + coordT'(1);
    pv1Neg = pv1[IW-1];
    negC  = xPrim ? (ccwR ? pv1Neg : !pv1Neg) : (ccwR ? !pv1Neg : pv1Neg);
    cv1   = negC ? cv - coordT'(1) : cv + coordT'(1);
    twoP  = errT'(pv) <<< 1;
    twoC  = errT'(cv) <<< 1;
    fA    = f + (negP ? -twoP : twoP) + errT'(1);
    fB    = fA + (negC ? -twoC : twoC) + errT'(1);
    magA  = fA[FW-1] ? -fA : fA;
    magB  = fB[FW-1] ? -fB : fB;
    diag  = (magB < magA);
    fN    = diag ? fB : fA;
    nx    = xPrim ? pv1 : (diag ? cv1 : cv);
    ny    = xPrim ? (diag ? cv1 : cv) : pv1;
    stepXn = xPrim | diag;
    stepYn = !xPrim | diag;
    dirXn = xPrim ? !negP : !negC;
    dirYn = xPrim ? !negC : !negP;
    dxE   = nx - ex;
    dyE   = ny - ey;
    exactN = (dxE == coordT'(0)) && (dyE == coordT'(0));
    nearN  = within1(dxE) && within1(dyE);
    finish = exactN || (nearN && armed);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      px    <= '0;
      py    <= '0;
      ex    <= '0;
      ey    <= '0;
      f     <= '0;
      armed <= 1'b0;
      ccwR  <= 1'b0;
      stepX <= 1'b0;
      stepY <= 1'b0;
      dirX  <= 1'b0;
      dirY  <= 1'b0;
    end else begin
      stepX <= 1'b0;
      stepY <= 1'b0;
      if (strobe.load) begin
        px    <= sAx - cAx;
        py    <= sAy - cAy;
        ex    <= eAx - cAx;
        ey    <= eAy - cAy;
        f     <= '0;
        armed <= 1'b0;
        ccwR  <= ccw;
      end else if (strobe.advance) begin
        px    <= nx;
        py    <= ny;
        f     <= fN;
        armed <= armed | ~nearN;
        stepX <= stepXn;
        stepY <= stepYn;
        if (stepXn) dirX <= dirXn;
        if (stepYn) dirY <= dirYn;
      end
    end
  end
endmodule

// File: rtl/arcStepper.sv
module arcStepper
  import arcPkg::*;
#(
  parameter int CW = 32,
  parameter int RW = 24,
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          absMode,
  input  logic          ccw,
  input  logic          constSpeed,
  input  logic [PW-1:0] period,
  input  logic [CW-1:0] startX,
  input  logic [CW-1:0] startY,
  input  logic [CW-1:0] centerX,
  input  logic [CW-1:0] centerY,
  input  logic [CW-1:0] endX,
  input  logic [CW-1:0] endY,
  output logic          stepX,
  output logic          stepY,
  output logic          dirX,
  output logic          dirY,
  output logic          busy,
  output logic          done
);
  arcStrobeT strobe;
  logic      zeroRad, finish, diag;

  arcCtrl #(.PW(PW)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .constSpeed(constSpeed),
    .period(period), .zeroRad(zeroRad), .finish(finish), .diag(diag),
    .strobe(strobe), .busy(busy), .done(done)
  );

  arcDatapath #(.CW(CW), .RW(RW)) u_path (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .startX(startX), .startY(startY), .centerX(centerX), .centerY(centerY),
    .endX(endX), .endY(endY), .absMode(absMode), .ccw(ccw),
    .zeroRad(zeroRad), .finish(finish), .diag(diag),
    .stepX(stepX), .stepY(stepY), .dirX(dirX), .dirY(dirY)
  );
endmodule

// File: rtl/arcStepperChk.sv
module arcStepperChk (
  input logic clk,
  input logic rstN,
  input logic stepX,
  input logic stepY,
  input logic dirX,
  input logic dirY,
  input logic busy,
  input logic done
);
  AST_STEP_IN_MOVE: assert property (@(posedge clk) disable iff (!rstN)
    (stepX || stepY) |-> (busy || done)); // R3
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R7
  AST_BUSY_END_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R7
  AST_LAST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (done && $past(busy)) |-> (stepX || stepY)); // R7
  AST_DIRX_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stepX |-> $stable(dirX)); // R4
  AST_DIRY_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !stepY |-> $stable(dirY)); // R4
endmodule

bind arcStepper arcStepperChk u_arcChk (
  .clk(clk), .rstN(rstN), .stepX(stepX), .stepY(stepY),
  .dirX(dirX), .dirY(dirY), .busy(busy), .done(done)
);

// File: tb/test_arcStepper.sv
module test_arcStepper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, absMode = 1'b0, ccw = 1'b0, constSpeed = 1'b0;
  logic [15:0] period = '0;
  logic [31:0] startX = '0, startY = '0, centerX = '0, centerY = '0, endX = '0, endY = '0;
  logic        stepX, stepY, dirX, dirY, busy, done;

  always #(CLK_PERIOD/2) clk = ~clk;

  arcStepper i_arcStepper (
    .clk(clk), .rstN(rstN), .start(start), .absMode(absMode), .ccw(ccw),
    .constSpeed(constSpeed), .period(period), .startX(startX), .startY(startY),
    .centerX(centerX), .centerY(centerY), .endX(endX), .endY(endY),
    .stepX(stepX), .stepY(stepY), .dirX(dirX), .dirY(dirY), .busy(busy), .done(done)
  );

  int checks = 0, errors = 0;
  longint cyc = 0;
  bit live = 0;

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic longint stretchP(input longint p);
    return p + (p >> 2) + (p >> 3) + (p >> 5) + (p >> 7);
  endfunction

  function automatic longint absL(input longint v);
    return v < 0 ? -v : v;
  endfunction

  function automatic longint placeL(input logic [31:0] base, input logic [31:0] v, input bit am);
    if (am) return longint'($signed(v));
    return longint'($signed(base)) + longint'($signed(v[23:0]));
  endfunction

  // ---------------- behavioural reference model ----------------
  longint mx, my, mex, mey, mR2, mAcc;
  bit     mArmed, mCcw, mCs, mBusy, mDone, mStepX, mStepY, mDirX, mDirY;
  longint mP, mInt, mCnt, mSteps;

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      mBusy = 0; mDone = 0; mStepX = 0; mStepY = 0; mDirX = 0; mDirY = 0;
      mCnt = 0; mInt = 1; mSteps = 0;
    end else begin
      mDone = 0; mStepX = 0; mStepY = 0;
      if (!mBusy) begin
        if (start) begin
          longint cx0, cy0;
          cx0 = placeL(startX, centerX, absMode);
          cy0 = placeL(startY, centerY, absMode);
          mAcc = cyc;
          mSteps = 0;
          if (cx0 == longint'($signed(startX)) && cy0 == longint'($signed(startY))) begin
            mDone = 1;
          end else begin
            mx = longint'($signed(startX)) - cx0;
            my = longint'($signed(startY)) - cy0;
            mex = placeL(startX, endX, absMode) - cx0;
            mey = placeL(startY, endY, absMode) - cy0;
            mR2 = mx * mx + my * my;
            mArmed = 0; mCcw = ccw; mCs = constSpeed;
            mP = (period == 0) ? 1 : longint'(period);
            mInt = mP; mCnt = 0; mBusy = 1;
          end
        end
      end else if (mCnt == mInt - 1) begin
        longint sx, sy, x1, y1, ax1, ay1, eA, eB, ddx, ddy;
        bit both, nearE, exactE;
        sx = 0; sy = 0;
        if (absL(my) >= absL(mx)) begin
          sx = (my >= 0) ? (mCcw ? -1 : 1) : (mCcw ? 1 : -1);
          x1 = mx + sx;
          ay1 = (x1 >= 0) ? (mCcw ? 1 : -1) : (mCcw ? -1 : 1);
          eA = absL(x1 * x1 + my * my - mR2);
          eB = absL(x1 * x1 + (my + ay1) * (my + ay1) - mR2);
          if (eB < eA) sy = ay1;
        end else begin
          sy = (mx >= 0) ? (mCcw ? 1 : -1) : (mCcw ? -1 : 1);
          y1 = my + sy;
          ax1 = (y1 >= 0) ? (mCcw ? -1 : 1) : (mCcw ? 1 : -1);
          eA = absL(mx * mx + y1 * y1 - mR2);
          eB = absL((mx + ax1) * (mx + ax1) + y1 * y1 - mR2);
          if (eB < eA) sx = ax1;
        end
        mx = mx + sx; my = my + sy;
        mStepX = (sx != 0); mStepY = (sy != 0);
        if (mStepX) mDirX = (sx > 0);
        if (mStepY) mDirY = (sy > 0);
        both = mStepX && mStepY;
        mSteps = mSteps + 1;
        ddx = mx - mex; ddy = my - mey;
        exactE = (ddx == 0) && (ddy == 0);
        nearE = (absL(ddx) <= 1) && (absL(ddy) <= 1);
        if (exactE || (nearE && mArmed)) begin
          mBusy = 0; mDone = 1;
        end
        if (!nearE) mArmed = 1;
        mCnt = 0;
        mInt = (mCs && both) ? stretchP(mP) : mP;
      end else begin
        mCnt = mCnt + 1;
      end
    end
  end

  // ---------------- monitor: trace compare, position, gaps ----------------
  longint bcx, bcy, br, tx, ty, bPe, lastCyc, dutSteps;
  bit     bCs, firstPending, lastDiag;

  always @(negedge clk) begin
    if (live) begin
      chk(stepX == mStepX, "R5 stepX trace", stepX, mStepX);
      chk(stepY == mStepY, "R5 stepY trace", stepY, mStepY);
      chk(dirX == mDirX, "R4 dirX trace", dirX, mDirX);
      chk(dirY == mDirY, "R4 dirY trace", dirY, mDirY);
      chk(busy == mBusy, "R3 busy trace", busy, mBusy);
      chk(done == mDone, "R7 done trace", done, mDone);
      if (stepX || stepY) begin
        longint gap, expGap, d2;
        gap = firstPending ? cyc - mAcc : cyc - lastCyc;
        expGap = firstPending ? bPe : ((bCs && lastDiag) ? stretchP(bPe) : bPe);
        chk(gap == expGap, firstPending ? "R3 first step delay" : "R9 step interval",
            gap, expGap);
        firstPending = 0;
        lastCyc = cyc;
        lastDiag = stepX && stepY;
        dutSteps = dutSteps + 1;
        if (stepX) tx = tx + (dirX ? 1 : -1);
        if (stepY) ty = ty + (dirY ? 1 : -1);
        d2 = (tx - bcx) * (tx - bcx) + (ty - bcy) * (ty - bcy);
        chk(d2 >= (br - 1) * (br - 1) && d2 <= (br + 1) * (br + 1), "R6 radial error",
            d2, br * br);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic runArc(input logic [31:0] sx, sy, cx, cy, ex, ey,
                        input bit am, dirCcw, cs, input int p,
                        input longint tcx, tcy, tex, tey, r,
                        input bit full, input bit poke, input string tag);
    int n;
    @(negedge clk);
    bcx = tcx; bcy = tcy; br = r;
    tx = longint'($signed(sx)); ty = longint'($signed(sy));
    bPe = (p == 0) ? 1 : p; bCs = cs; firstPending = 1; lastDiag = 0; dutSteps = 0;
    startX = sx; startY = sy; centerX = cx; centerY = cy; endX = ex; endY = ey;
    absMode = am; ccw = dirCcw; constSpeed = cs; period = 16'(p);
    start = 1;
    @(negedge clk);
    start = 0;
    n = 0;
    while (done !== 1'b1) begin
      @(negedge clk);
      n++;
      if (poke && n == 20) begin
        start = 1; ccw = ~dirCcw; period = 16'd1; centerX = 32'd7;
      end else begin
        start = 0;
      end
    end
    start = 0;
    @(posedge clk);
    #1;
    chk(absL(tx - tex) <= 1, {tag, " R7 end X"}, tx, tex);
    chk(absL(ty - tey) <= 1, {tag, " R7 end Y"}, ty, tey);
    chk(busy == 1'b0, {tag, " R7 busy low after done"}, busy, 0);
    chk(dutSteps == mSteps, {tag, " R10 step count"}, dutSteps, mSteps);
    if (full) chk(dutSteps >= 4 * r, {tag, " R8 whole circle steps"}, dutSteps, 4 * r);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(stepX == 0 && stepY == 0, "R1 steps in reset", {stepX, stepY}, 0);
    chk(busy == 0 && done == 0, "R1 status in reset", {busy, done}, 0);
    rstN = 1;
    @(negedge clk);
    chk(dirX == 0 && dirY == 0, "R1 dirs after reset", {dirX, dirY}, 0);
    chk(busy == 0 && done == 0, "R1 idle after reset", {busy, done}, 0);
    live = 1;

    // quarter arc, absolute, counter-clockwise
    runArc(32'd110, 32'd50, 32'd100, 32'd50, 32'd100, 32'd60, 1, 1, 0, 3,
           100, 50, 100, 60, 10, 0, 0, "R2 R5 ccw quarter");
    // quarter arc back, clockwise, period zero
    runArc(32'd100, 32'd60, 32'd100, 32'd50, 32'd110, 32'd50, 1, 0, 0, 0,
           100, 50, 110, 50, 10, 0, 0, "R3 R5 cw period zero");
    // half circle, relative offsets with junk in the upper byte, constant speed
    runArc(32'd0, 32'd0, 32'hABFF_FFF6, 32'h1200_0000, 32'h55FF_FFEC, 32'h0000_0000,
           0, 1, 1, 4, -10, 0, -20, 0, 10, 0, 0, "R2 R9 relative half");
    // whole circle, clockwise, constant speed, extra start pulse while busy
    runArc(32'd1000, 32'd2000, 32'hFFFF_FFFB, 32'd0, 32'd0, 32'd0,
           0, 0, 1, 8, 995, 2000, 1000, 2000, 5, 1, 1, "R8 R10 full circle");
    // quarter arc at the top of the 32-bit range
    runArc(32'h7FFF_FFFF, 32'h8000_0001, 32'h7FFF_FFD0, 32'h8000_0001,
           32'h7FFF_FFD0, 32'h8000_0030, 1, 1, 0, 2,
           64'sd2147483600, -64'sd2147483647, 64'sd2147483600, -64'sd2147483600,
           47, 0, 0, "R2 wide coords");
    // end point one unit off the circle
    runArc(32'd10, 32'd0, 32'd0, 32'd0, 32'd0, 32'd11, 1, 1, 0, 1,
           0, 0, 0, 11, 10, 0, 0, "R7 near end");

    // zero radius
    @(negedge clk);
    firstPending = 0;
    startX = 32'd5; startY = 32'd5; centerX = 32'd5; centerY = 32'd5;
    absMode = 1; period = 16'd3; start = 1;
    @(negedge clk);
    start = 0;
    chk(done == 1 && busy == 0, "R11 zero radius done", {done, busy}, 2);
    chk(stepX == 0 && stepY == 0, "R11 zero radius no step", {stepX, stepY}, 0);
    @(negedge clk);
    chk(done == 0 && busy == 0, "R11 zero radius idle", {done, busy}, 0);

    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule